// File: doc/BRIEF.md
# Dual-Register Logic Cell

This block is one output cell of a sum-of-products logic fabric. It takes twelve product-term inputs and divides them between two sum terms at a configurable split point. Each sum term drives its own flip-flop. Each flip-flop has its own settings: D or T behaviour, and a clock taken either from its private clock term or from a shared clock pin. Each flip-flop also has its own reset term. A single preset input is shared by both. Both register states go back to the array on separate feedback lines. Only the first register, or the first sum term when combinatorial output is selected, reaches the pin, through a polarity inverter and under its own output-enable term.

All logic runs on one system clock. The clock pin and the two clock terms are sampled as ordinary signals. A register updates on the system-clock edge at which its selected source is first seen high. A test preload mode uses that same edge to write the raw pin level into whichever register the select input names.

Top module: `mc_macrocell`

## Requirements
- R1: After power-up reset both registers and both feedback outputs are 0, and `pin_out` equals `cfg_invert`.
- R2: Sum term 0 is the OR of `ptm[s-1:0]` and sum term 1 is the OR of the remaining bits of `ptm`. Here s is `cfg_split` clamped to the range 4 to 8, so values below 4 act as 4 and values above 8 act as 8.
- R3: A D-mode register takes its data value on the system-clock edge at which its selected clock source is first seen high. Holding the source high, or lowering it, leaves the register unchanged.
- R4: A T-mode register (`cfg_t_mode[i]=1`) inverts on a clock event when its data value is 1.
- R5: With `cfg_pin_clk[i]=1` register i is clocked by `clk_pin`, and with 0 by `clk_term[i]`. A rising level on the source that is not selected has no effect on that register.
- R6: While `arst_term[i]` is 1, feedback bit i (and the pin, for register 0) reads 0 in the same cycle, independent of any clock. The register holds 0 after the term drops.
- R7: On a clock event with `sync_preset=1` a register becomes 1. If its reset term is also active it becomes 0 instead.
- R8: With `preload_en=1`, a clock event of register i loads the raw `pin_in` into that register only if `preload_sel` names it (0 selects register 0, 1 selects register 1), whatever `cfg_invert` is. The other register keeps its value, and `pin_oe` is 0 throughout preload.
- R9: `pin_out` is the register 0 state, or with `cfg_comb=1` the register 0 data value, XOR `cfg_invert`. The register 0 data value is sum 0, or sum 0 OR sum 1 when `cfg_joint=1`. Register 1 always takes sum 1 and appears only on `fb_q[1]`.
- R10: Outside preload, `pin_oe` follows `oe_term`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, active low |
| ptm | input | 12 | Product-term values from the array |
| cfg_split | input | 4 | Number of product terms assigned to sum 0 |
| cfg_t_mode | input | 2 | Per-register T-mode select |
| cfg_pin_clk | input | 2 | Per-register clock source: 1 = pin, 0 = term |
| cfg_comb | input | 1 | Combinatorial pin output |
| cfg_joint | input | 1 | OR both sums into register 0 data |
| cfg_invert | input | 1 | Output polarity inversion |
| clk_pin | input | 1 | Shared clock pin level |
| clk_term | input | 2 | Per-register clock product terms |
| arst_term | input | 2 | Per-register reset product terms |
| sync_preset | input | 1 | Shared preset, applied on clock events |
| oe_term | input | 1 | Output-enable product term |
| preload_en | input | 1 | Test preload mode |
| preload_sel | input | 1 | Preload target register |
| pin_in | input | 1 | Pin level used by preload |
| pin_out | output | 1 | Pin data |
| pin_oe | output | 1 | Pin output enable |
| fb_q | output | 2 | Feedback from both registers |

## Verification
A register responds to a clock event one system clock after the bench raises the source. The new state, and the pin level derived from it, are due just after the next rising edge. Reset masking, the combinatorial path, the sum split and the output enable are all combinational, so they are also correct at that point. The driver applies stimulus on the falling edge and queues the expected value tagged with the following cycle number. The monitor compares one time unit after each rising edge, so every result is read exactly once, in the cycle it is due.

// File: rtl/mc_pkg.sv
package mc_pkg;
    localparam int NUM_REG = 2;

    typedef struct packed {
        logic [NUM_REG-1:0] q;
        logic               clk_pin_p;
        logic [NUM_REG-1:0] clk_term_p;
    } mc_state_t;
endpackage

// File: rtl/mc_sum_split.sv
module mc_sum_split #(
    parameter int PT_TOTAL = 12,
    parameter int PT_MIN   = 4,
    parameter int PT_MAX   = 8,
    parameter int SPLIT_W  = 4
) (
    input  logic [PT_TOTAL-1:0] ptm,
    input  logic [SPLIT_W-1:0]  cfg_split,
    output logic                sum0,
    output logic                sum1
);
    logic [SPLIT_W-1:0]  split_eff;
    logic [PT_TOTAL-1:0] own0;

    always_comb begin
        if (cfg_split < SPLIT_W'(PT_MIN))
            split_eff = SPLIT_W'(PT_MIN);
        else if (cfg_split > SPLIT_W'(PT_MAX))
            split_eff = SPLIT_W'(PT_MAX);
        else
            split_eff = cfg_split;
    end

    for (genvar k = 0; k < PT_TOTAL; k++) begin : g_own
        assign own0[k] = (SPLIT_W'(k) < split_eff);
    end

    assign sum0 = |(ptm & own0);
    assign sum1 = |(ptm & ~own0);
endmodule

// File: rtl/mc_clk_pick.sv
module mc_clk_pick (
    input  logic sel_pin,
    input  logic pin_now,
    input  logic pin_prev,
    input  logic term_now,
    input  logic term_prev,
    output logic rise
);
    always_comb begin
        if (sel_pin)
            rise = pin_now & ~pin_prev;
        else
            rise = term_now & ~term_prev;
    end
endmodule

// File: rtl/mc_reg_next.sv
module mc_reg_next (
    input  logic q,
    input  logic rise,
    input  logic arst,
    input  logic preset,
    input  logic preload_en,
    input  logic preload_hit,
    input  logic pin_in,
    input  logic t_mode,
    input  logic data,
    output logic q_next
);
    always_comb begin
        if (arst)
            q_next = 1'b0;
        else if (!rise)
            q_next = q;
        else if (preload_en)
            q_next = preload_hit ? pin_in : q;
        else if (preset)
            q_next = 1'b1;
        else if (t_mode)
            q_next = q ^ data;
        else
            q_next = data;
    end
endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
    import mc_pkg::*;
#(
    parameter  int PT_TOTAL = 12,
    parameter  int PT_MIN   = 4,
    parameter  int PT_MAX   = 8,
    localparam int SPLIT_W  = $clog2(PT_TOTAL + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PT_TOTAL-1:0] ptm,
    input  logic [SPLIT_W-1:0]  cfg_split,
    input  logic [NUM_REG-1:0]  cfg_t_mode,
    input  logic [NUM_REG-1:0]  cfg_pin_clk,
    input  logic                cfg_comb,
    input  logic                cfg_joint,
    input  logic                cfg_invert,
    input  logic                clk_pin,
    input  logic [NUM_REG-1:0]  clk_term,
    input  logic [NUM_REG-1:0]  arst_term,
    input  logic                sync_preset,
    input  logic                oe_term,
    input  logic                preload_en,
    input  logic                preload_sel,
    input  logic                pin_in,
    output logic                pin_out,
    output logic                pin_oe,
    output logic [NUM_REG-1:0]  fb_q
);
    mc_state_t          st_d, st_q;
    logic               sum0, sum1;
    logic               data0;
    logic [NUM_REG-1:0] data_in;
    logic [NUM_REG-1:0] rise;
    logic [NUM_REG-1:0] q_nxt;

    mc_sum_split #(
        .PT_TOTAL(PT_TOTAL), .PT_MIN(PT_MIN), .PT_MAX(PT_MAX), .SPLIT_W(SPLIT_W)
    ) u_split (
        .ptm(ptm), .cfg_split(cfg_split), .sum0(sum0), .sum1(sum1)
    );

    assign data0      = cfg_joint ? (sum0 | sum1) : sum0;
    assign data_in[0] = data0;
    assign data_in[1] = sum1;

    for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
        mc_clk_pick u_pick (
            .sel_pin  (cfg_pin_clk[i]),
            .pin_now  (clk_pin),
            .pin_prev (st_q.clk_pin_p),
            .term_now (clk_term[i]),
            .term_prev(st_q.clk_term_p[i]),
            .rise     (rise[i])
        );
        mc_reg_next u_next (
            .q          (st_q.q[i]),
            .rise       (rise[i]),
            .arst       (arst_term[i]),
            .preset     (sync_preset),
            .preload_en (preload_en),
            .preload_hit(preload_sel == 1'(i)),
            .pin_in     (pin_in),
            .t_mode     (cfg_t_mode[i]),
            .data       (data_in[i]),
            .q_next     (q_nxt[i])
        );
    end

    always_comb begin
        st_d            = st_q;
        st_d.q          = q_nxt;
        st_d.clk_pin_p  = clk_pin;
        st_d.clk_term_p = clk_term;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign fb_q    = st_q.q & ~arst_term;
    assign pin_out = (cfg_comb ? data0 : fb_q[0]) ^ cfg_invert;
    assign pin_oe  = oe_term & ~preload_en;
endmodule

// File: rtl/mc_macrocell_chk.sv
module mc_macrocell_chk #(
    parameter int PT_TOTAL = 12,
    parameter int PT_MIN   = 4,
    parameter int SPLIT_W  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [PT_TOTAL-1:0] ptm,
    input logic [SPLIT_W-1:0]  cfg_split,
    input logic [1:0]          cfg_pin_clk,
    input logic                cfg_comb,
    input logic                cfg_joint,
    input logic                cfg_invert,
    input logic                clk_pin,
    input logic [1:0]          clk_term,
    input logic [1:0]          arst_term,
    input logic                sync_preset,
    input logic                oe_term,
    input logic                preload_en,
    input logic                pin_out,
    input logic                pin_oe,
    input logic [1:0]          fb_q
);
    logic       p_pin;
    logic [1:0] p_term;
    logic [1:0] ev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_pin  <= 1'b0;
            p_term <= 2'b00;
        end else begin
            p_pin  <= clk_pin;
            p_term <= clk_term;
        end
    end

    assign ev[0] = cfg_pin_clk[0] ? (clk_pin & ~p_pin) : (clk_term[0] & ~p_term[0]);
    assign ev[1] = cfg_pin_clk[1] ? (clk_pin & ~p_pin) : (clk_term[1] & ~p_term[1]);

    AST_ARST_MASK0: assert property (@(posedge clk) disable iff (!rst_n)
        arst_term[0] |-> (!fb_q[0] && (cfg_comb || pin_out == cfg_invert))); // R6
    AST_ARST_MASK1: assert property (@(posedge clk) disable iff (!rst_n)
        arst_term[1] |-> !fb_q[1]); // R6
    AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[0] && sync_preset && !preload_en && !arst_term[0]) |=> (fb_q[0] || arst_term[0])); // R7
    AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev[1] && !arst_term[1]) |=> (fb_q[1] == $past(fb_q[1]) || arst_term[1])); // R3
    AST_OE_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        preload_en |-> !pin_oe); // R8
    AST_OE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !preload_en |-> (pin_oe == oe_term)); // R10
    AST_COMB_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_comb && !cfg_joint && cfg_split == SPLIT_W'(PT_MIN))
            |-> (pin_out == ((|ptm[PT_MIN-1:0]) ^ cfg_invert))); // R9
endmodule

bind mc_macrocell mc_macrocell_chk #(
    .PT_TOTAL(PT_TOTAL), .PT_MIN(PT_MIN), .SPLIT_W(SPLIT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ptm(ptm), .cfg_split(cfg_split),
    .cfg_pin_clk(cfg_pin_clk), .cfg_comb(cfg_comb), .cfg_joint(cfg_joint),
    .cfg_invert(cfg_invert), .clk_pin(clk_pin), .clk_term(clk_term),
    .arst_term(arst_term), .sync_preset(sync_preset), .oe_term(oe_term),
    .preload_en(preload_en), .pin_out(pin_out), .pin_oe(pin_oe), .fb_q(fb_q)
);

// File: tb/mc_macrocell_tb.sv
`timescale 1ns/1ps
module mc_macrocell_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] ptm = '0;
    logic [3:0]  cfg_split = 4'd4;
    logic [1:0]  cfg_t_mode = '0, cfg_pin_clk = '0;
    logic        cfg_comb = 0, cfg_joint = 0, cfg_invert = 0;
    logic        clk_pin = 0;
    logic [1:0]  clk_term = '0, arst_term = '0;
    logic        sync_preset = 0, oe_term = 0, preload_en = 0, preload_sel = 0, pin_in = 0;
    logic        pin_out, pin_oe;
    logic [1:0]  fb_q;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;
    int    due_q[$];
    logic [7:0] mv_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    mc_macrocell u_dut (
        .clk(clk), .rst_n(rst_n), .ptm(ptm), .cfg_split(cfg_split),
        .cfg_t_mode(cfg_t_mode), .cfg_pin_clk(cfg_pin_clk), .cfg_comb(cfg_comb),
        .cfg_joint(cfg_joint), .cfg_invert(cfg_invert), .clk_pin(clk_pin),
        .clk_term(clk_term), .arst_term(arst_term), .sync_preset(sync_preset),
        .oe_term(oe_term), .preload_en(preload_en), .preload_sel(preload_sel),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .fb_q(fb_q)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: observed bits are {pin_out, pin_oe, fb_q[1], fb_q[0]}
    initial forever begin
        @(posedge clk);
        #1;
        while (due_q.size() > 0 && due_q[0] <= cyc) begin
            logic [3:0] m, v, obs;
            string t;
            m = mv_q[0][7:4];
            v = mv_q[0][3:0];
            t = tag_q[0];
            void'(due_q.pop_front());
            void'(mv_q.pop_front());
            void'(tag_q.pop_front());
            obs = {pin_out, pin_oe, fb_q};
            checks++;
            if ((obs & m) != (v & m)) begin
                fails++;
                $display("FAIL %s cycle %0d: actual %b expected %b (mask %b)", t, cyc, obs, v, m);
            end
        end
    end

    task automatic chk(input logic [3:0] m, input logic [3:0] v, input string tag);
        due_q.push_back(cyc + 1);
        mv_q.push_back({m, v});
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk(4'b1111, 4'b0000, "R1 reset state");
        cfg_invert = 1;
        chk(4'b1000, 4'b1000, "R1 polarity after reset");
        cfg_invert = 0; ptm[0] = 1; clk_term[0] = 1;
        chk(4'b1011, 4'b1001, "R3 D capture");
        ptm[0] = 0;
        chk(4'b0001, 4'b0001, "R3 held high no new event");
        clk_term[0] = 0; cfg_t_mode[1] = 1; ptm[4] = 1;
        chk(4'b0011, 4'b0001, "R3 falling level no event");
        clk_term[1] = 1;
        chk(4'b1011, 4'b1011, "R4 toggle up, R9 pin from reg0");
        clk_term[1] = 0;
        chk(4'b0010, 4'b0010, "R4 no event hold");
        clk_term[1] = 1;
        chk(4'b0010, 4'b0000, "R4 toggle down");
        cfg_pin_clk[0] = 1; clk_pin = 1;
        chk(4'b0011, 4'b0000, "R5 pin clock captures");
        clk_term[0] = 1; ptm[0] = 1;
        chk(4'b0001, 4'b0000, "R5 unselected term ignored");
        clk_pin = 0; clk_term = 2'b00; ptm[0] = 0;
        chk(4'b0011, 4'b0000, "R5 idle");
        clk_term[1] = 1;
        chk(4'b0010, 4'b0010, "R4 toggle again");
        arst_term[1] = 1;
        chk(4'b0010, 4'b0000, "R6 immediate clear");
        arst_term[1] = 0;
        chk(4'b0010, 4'b0000, "R6 stays clear");
        sync_preset = 1; clk_pin = 1;
        chk(4'b0011, 4'b0001, "R7 preset sets on event only");
        sync_preset = 0; clk_pin = 0;
        chk(4'b0001, 4'b0001, "R7 preset held");
        clk_pin = 1; sync_preset = 1; arst_term[0] = 1;
        chk(4'b1001, 4'b0000, "R7 reset beats preset");
        arst_term[0] = 0; sync_preset = 0; clk_pin = 0;
        chk(4'b0001, 4'b0000, "R7 after priority");
        preload_en = 1; preload_sel = 1; pin_in = 1; oe_term = 1; clk_term[1] = 0;
        chk(4'b0100, 4'b0000, "R8 oe off in preload");
        clk_term[1] = 1;
        chk(4'b0111, 4'b0010, "R8 load reg1 only");
        preload_sel = 0; cfg_invert = 1; clk_pin = 1;
        chk(4'b1111, 4'b0011, "R8 raw load reg0");
        preload_en = 0; clk_pin = 0; cfg_invert = 0;
        chk(4'b1101, 4'b1101, "R10 oe follows term");
        oe_term = 0;
        chk(4'b0100, 4'b0000, "R10 oe low");
        cfg_comb = 1; ptm = 12'h010;
        chk(4'b1000, 4'b0000, "R9 comb separate");
        cfg_joint = 1;
        chk(4'b1000, 4'b1000, "R9 comb joint");
        cfg_joint = 0; cfg_split = 4'd8;
        chk(4'b1000, 4'b1000, "R2 split 8");
        cfg_split = 4'd2;
        chk(4'b1000, 4'b0000, "R2 clamp low");
        cfg_split = 4'd15; ptm = 12'h100;
        chk(4'b1000, 4'b0000, "R2 clamp high upper bit");
        ptm = 12'h080;
        chk(4'b1000, 4'b1000, "R2 clamp high bit 7");
        cfg_comb = 0; cfg_split = 4'd4; cfg_joint = 1; ptm = '0; clk_pin = 1;
        chk(4'b1001, 4'b0000, "R9 registered clear");
        clk_pin = 0; ptm = 12'h010;
        chk(4'b0001, 4'b0000, "R9 no event");
        clk_pin = 1;
        chk(4'b1001, 4'b1001, "R9 joint into reg0");
        cfg_joint = 0; clk_pin = 0;
        chk(4'b0001, 4'b0001, "R9 hold");
        clk_pin = 1;
        chk(4'b1001, 4'b0000, "R9 separate into reg0");
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule